// File: doc/BRIEF.md
# Wide-Vector Lane Group Sequencer

This block runs one logical wide-vector instruction across a narrower physical SIMD array. Several wide thread contexts (waves) are resident at the same time. Each wave has its own program counter and its own active lane mask. When the sequencer is idle it picks a ready wave in round-robin order and accepts that wave's instruction. For an arithmetic instruction it then walks the logical vector one lane group per cycle. Each cycle it drives the group index, the wave ID, the wave's program counter and sixteen per-lane enables taken from the active mask.

Divergent control flow runs as predicated execution. A branch instruction saves the wave's active mask on a private stack and narrows the mask to the lanes whose condition bit is set. A reconverge instruction restores the saved mask. Both control instructions finish in the cycle they are accepted and issue no lane groups. An arithmetic instruction whose active mask is empty inside its vector length is retired without issuing anything, so a path that no lane takes costs no lane cycles. The vector length is chosen per instruction: full length (four groups) or half length (two groups).

Top module: `wave_lane_seq`

## Requirements
- R1: A full-length arithmetic instruction (vlen32_i = 0 when accepted) holds grp_valid_o high for four consecutive cycles, starting the cycle after acceptance, with grp_idx_o = 0, 1, 2, 3 in that order.
- R2: A half-length arithmetic instruction (vlen32_i = 1 when accepted) issues exactly two groups, 0 then 1.
- R3: While a group issues, lane_en_o bit i equals bit 16*grp_idx_o + i of the issuing wave's active mask. lane_en_o is zero when no group issues.
- R4: op_i = 2'b01 (branch) saves the active mask and sets the mask to the old mask AND cond_i. It issues no group.
- R5: op_i = 2'b10 (reconverge) restores the most recently saved mask. It issues no group.
- R6: An arithmetic instruction (op_i = 2'b00 or 2'b11) whose active mask has no set bit within its vector length issues no group. Its program counter still advances.
- R7: A branch when the wave already holds STACK_DEPTH saved masks, or a reconverge when it holds none, sets err_o. err_o stays set until reset, and the mask does not change.
- R8: The sequencer accepts a wave only when idle and at least one ready_i bit is set. It then takes the first ready wave after the previously accepted one, in cyclic order, and shows that wave on sel_valid_o / sel_wave_o.
- R9: Once groups are issuing, no other wave is accepted until the last group has issued, and wave_id_o stays constant.
- R10: Each wave's program counter starts at 0 and advances by one for every instruction of that wave that completes. pc_o shows it during issue.
- R11: After reset nothing issues, err_o is 0, every mask is all ones and the first wave accepted is the lowest-numbered ready one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ready_i | input | NUM_WAVES | Per-wave ready flags |
| op_i | input | 2 | Instruction kind of the wave accepted this cycle |
| vlen32_i | input | 1 | 1 selects half vector length |
| cond_i | input | VEC_LEN | Per-element branch condition |
| sel_valid_o | output | 1 | A wave is accepted this cycle |
| sel_wave_o | output | $clog2(NUM_WAVES) | Wave being accepted |
| grp_valid_o | output | 1 | A lane group issues this cycle |
| grp_idx_o | output | $clog2(VEC_LEN/LANES) | Lane group index |
| lane_en_o | output | LANES | Per-lane enables |
| wave_id_o | output | $clog2(NUM_WAVES) | Issuing wave |
| pc_o | output | PC_W | Program counter of the issuing wave |
| err_o | output | 1 | Sticky mask stack fault |

## Verification
The bench uses the default build: eight waves, sixteen lanes, a 64-element vector and a stack depth of three. With only three saved masks per wave, short runs of branches reach overflow, and early reconverges reach underflow. Eight waves with sparse ready patterns exercise the round-robin wrap from the highest wave back to wave 0. Branch conditions that include all-zero and half-zero patterns lead to empty masks at both vector lengths.

// File: rtl/wls_pkg.sv
package wls_pkg;
  typedef enum logic [1:0] {
    OP_ALU    = 2'b00,
    OP_BRANCH = 2'b01,
    OP_JOIN   = 2'b10,
    OP_ALU2   = 2'b11
  } op_e;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_ISSUE = 1'b1
  } st_e;
endpackage

// File: rtl/wls_rr_pick.sv
module wls_rr_pick #(
  parameter int N = 8,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] req_i,
  input  logic [W-1:0] last_i,
  output logic         gnt_valid_o,
  output logic [W-1:0] gnt_idx_o
);
  logic [W-1:0] pos;

  // scan downward so the nearest candidate after last_i wins
  always_comb begin
    gnt_valid_o = 1'b0;
    gnt_idx_o   = '0;
    pos         = '0;
    for (int k = N; k >= 1; k--) begin
      pos = W'((int'(last_i) + k) % N);
      if (req_i[pos]) begin
        gnt_valid_o = 1'b1;
        gnt_idx_o   = pos;
      end
    end
  end
endmodule

// File: rtl/wls_mask_stack.sv
module wls_mask_stack #(
  parameter int VEC_LEN = 64,
  parameter int DEPTH   = 3,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push_i,
  input  logic               pop_i,
  input  logic [VEC_LEN-1:0] cond_i,
  output logic [VEC_LEN-1:0] top_o,
  output logic               fault_o
);
  logic [VEC_LEN-1:0] top_q, top_d;
  logic [CW-1:0]      cnt_q, cnt_d;
  logic [VEC_LEN-1:0] save_q [DEPTH];
  logic               wr_en;

  always_comb begin
    top_d   = top_q;
    cnt_d   = cnt_q;
    wr_en   = 1'b0;
    fault_o = 1'b0;
    if (push_i) begin
      if (cnt_q == CW'(DEPTH)) begin
        fault_o = 1'b1;
      end else begin
        top_d = top_q & cond_i;
        cnt_d = cnt_q + 1'b1;
        wr_en = 1'b1;
      end
    end else if (pop_i) begin
      if (cnt_q == '0) begin
        fault_o = 1'b1;
      end else begin
        top_d = save_q[IW'(cnt_q - 1'b1)];
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_q <= '1;
      cnt_q <= '0;
    end else begin
      top_q <= top_d;
      cnt_q <= cnt_d;
    end
  end

  // saved entries need no reset: they are read only below cnt_q
  always_ff @(posedge clk) begin
    if (wr_en) save_q[IW'(cnt_q)] <= top_q;
  end

  assign top_o = top_q;
endmodule

// File: rtl/wave_lane_seq.sv
module wave_lane_seq #(
  parameter int NUM_WAVES   = 8,
  parameter int LANES       = 16,
  parameter int VEC_LEN     = 64,
  parameter int STACK_DEPTH = 3,
  parameter int PC_W        = 8,
  localparam int WID_W  = $clog2(NUM_WAVES),
  localparam int GROUPS = VEC_LEN / LANES,
  localparam int GRP_W  = $clog2(GROUPS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_WAVES-1:0] ready_i,
  input  logic [1:0]           op_i,
  input  logic                 vlen32_i,
  input  logic [VEC_LEN-1:0]   cond_i,
  output logic                 sel_valid_o,
  output logic [WID_W-1:0]     sel_wave_o,
  output logic                 grp_valid_o,
  output logic [GRP_W-1:0]     grp_idx_o,
  output logic [LANES-1:0]     lane_en_o,
  output logic [WID_W-1:0]     wave_id_o,
  output logic [PC_W-1:0]      pc_o,
  output logic                 err_o
);
  import wls_pkg::*;

  localparam logic [VEC_LEN-1:0] HALF_MASK = VEC_LEN'({(VEC_LEN/2){1'b1}});

  st_e              st_q, st_d;
  logic [GRP_W-1:0] grp_q, grp_d, last_grp;
  logic [WID_W-1:0] wave_q, wave_d, prev_q, prev_d;
  logic             short_q, short_d;
  logic             err_q, err_d;
  logic [PC_W-1:0]  pc_q [NUM_WAVES];
  logic [PC_W-1:0]  pc_d [NUM_WAVES];

  logic               gnt_valid, pick_fire;
  logic [WID_W-1:0]   gnt_idx;
  op_e                op_dec;
  logic [VEC_LEN-1:0] vmask;
  logic [VEC_LEN-1:0] top_m [NUM_WAVES];
  logic [NUM_WAVES-1:0] push_w, pop_w, fault_w;

  assign op_dec    = op_e'(op_i);
  assign pick_fire = (st_q == ST_IDLE) && gnt_valid;
  assign vmask     = vlen32_i ? HALF_MASK : '1;
  assign last_grp  = short_q ? GRP_W'(GROUPS/2 - 1) : GRP_W'(GROUPS - 1);

  wls_rr_pick #(.N(NUM_WAVES)) u_pick (
    .req_i       (ready_i),
    .last_i      (prev_q),
    .gnt_valid_o (gnt_valid),
    .gnt_idx_o   (gnt_idx)
  );

  for (genvar w = 0; w < NUM_WAVES; w++) begin : g_wave
    assign push_w[w] = pick_fire && (gnt_idx == WID_W'(w)) && (op_dec == OP_BRANCH);
    assign pop_w[w]  = pick_fire && (gnt_idx == WID_W'(w)) && (op_dec == OP_JOIN);
    wls_mask_stack #(.VEC_LEN(VEC_LEN), .DEPTH(STACK_DEPTH)) u_stk (
      .clk     (clk),
      .rst_n   (rst_n),
      .push_i  (push_w[w]),
      .pop_i   (pop_w[w]),
      .cond_i  (cond_i),
      .top_o   (top_m[w]),
      .fault_o (fault_w[w])
    );
  end

  always_comb begin
    st_d    = st_q;
    grp_d   = grp_q;
    wave_d  = wave_q;
    prev_d  = prev_q;
    short_d = short_q;
    err_d   = err_q | (|fault_w);
    pc_d    = pc_q;
    if (pick_fire) begin
      prev_d = gnt_idx;
      if ((op_dec == OP_BRANCH) || (op_dec == OP_JOIN) ||
          ((top_m[gnt_idx] & vmask) == '0)) begin
        pc_d[gnt_idx] = pc_q[gnt_idx] + 1'b1;
      end else begin
        st_d    = ST_ISSUE;
        grp_d   = '0;
        wave_d  = gnt_idx;
        short_d = vlen32_i;
      end
    end else if (st_q == ST_ISSUE) begin
      grp_d = grp_q + 1'b1;
      if (grp_q == last_grp) begin
        st_d          = ST_IDLE;
        pc_d[wave_q]  = pc_q[wave_q] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      grp_q   <= '0;
      wave_q  <= '0;
      prev_q  <= WID_W'(NUM_WAVES - 1);
      short_q <= 1'b0;
      err_q   <= 1'b0;
      for (int i = 0; i < NUM_WAVES; i++) pc_q[i] <= '0;
    end else begin
      st_q    <= st_d;
      grp_q   <= grp_d;
      wave_q  <= wave_d;
      prev_q  <= prev_d;
      short_q <= short_d;
      err_q   <= err_d;
      pc_q    <= pc_d;
    end
  end

  assign sel_valid_o = pick_fire;
  assign sel_wave_o  = gnt_idx;
  assign grp_valid_o = (st_q == ST_ISSUE);
  assign grp_idx_o   = grp_q;
  assign wave_id_o   = wave_q;
  assign pc_o        = pc_q[wave_q];
  assign err_o       = err_q;
  assign lane_en_o   = grp_valid_o ? top_m[wave_q][int'(grp_q)*LANES +: LANES] : '0;
endmodule

// File: rtl/wave_lane_seq_chk.sv
module wave_lane_seq_chk #(
  parameter int NUM_WAVES = 8,
  parameter int VEC_LEN   = 64,
  parameter int LANES     = 16,
  parameter int PC_W      = 8,
  localparam int WID_W = $clog2(NUM_WAVES),
  localparam int GRP_W = $clog2(VEC_LEN / LANES)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_WAVES-1:0] ready_i,
  input logic                 sel_valid_o,
  input logic [WID_W-1:0]     sel_wave_o,
  input logic                 grp_valid_o,
  input logic [GRP_W-1:0]     grp_idx_o,
  input logic [LANES-1:0]     lane_en_o,
  input logic [WID_W-1:0]     wave_id_o,
  input logic [PC_W-1:0]      pc_o,
  input logic                 err_o
);
  p_first_group_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_valid_o && grp_idx_o == '0) |=> (grp_valid_o && grp_idx_o == GRP_W'(1)));

  p_group_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_valid_o && $past(grp_valid_o)) |-> (grp_idx_o == $past(grp_idx_o) + 1'b1));

  p_quiet_lanes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !grp_valid_o |-> (lane_en_o == '0));

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);

  p_pick_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid_o |-> ready_i[sel_wave_o]);

  p_no_pick_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    grp_valid_o |-> !sel_valid_o);

  p_wave_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_valid_o && $past(grp_valid_o)) |-> ($stable(wave_id_o) && $stable(pc_o)));
endmodule

bind wave_lane_seq wave_lane_seq_chk #(
  .NUM_WAVES(NUM_WAVES), .VEC_LEN(VEC_LEN), .LANES(LANES), .PC_W(PC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ready_i(ready_i), .sel_valid_o(sel_valid_o),
  .sel_wave_o(sel_wave_o), .grp_valid_o(grp_valid_o), .grp_idx_o(grp_idx_o),
  .lane_en_o(lane_en_o), .wave_id_o(wave_id_o), .pc_o(pc_o), .err_o(err_o)
);

// File: tb/wave_lane_seq_tb.sv
module wave_lane_seq_tb;
  localparam int NW = 8;
  localparam int DEPTH = 3;

  logic        clk;
  logic        rst_n;
  logic [NW-1:0] ready_i;
  logic [1:0]  op_i;
  logic        vlen32_i;
  logic [63:0] cond_i;
  logic        sel_valid_o, grp_valid_o, err_o;
  logic [2:0]  sel_wave_o, wave_id_o;
  logic [1:0]  grp_idx_o;
  logic [15:0] lane_en_o;
  logic [7:0]  pc_o;

  wave_lane_seq u_dut (
    .clk(clk), .rst_n(rst_n), .ready_i(ready_i), .op_i(op_i), .vlen32_i(vlen32_i),
    .cond_i(cond_i), .sel_valid_o(sel_valid_o), .sel_wave_o(sel_wave_o),
    .grp_valid_o(grp_valid_o), .grp_idx_o(grp_idx_o), .lane_en_o(lane_en_o),
    .wave_id_o(wave_id_o), .pc_o(pc_o), .err_o(err_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit summary_done = 0;

  // reference model state
  int          m_st, m_grp, m_ngrp, m_wave, m_last;
  logic [63:0] m_mask [NW];
  logic [63:0] m_stk  [NW][DEPTH];
  int          m_cnt  [NW];
  logic [7:0]  m_pc   [NW];
  bit          m_err;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int rr(input logic [NW-1:0] rdy, input int last);
    for (int k = 1; k <= NW; k++) begin
      if (rdy[(last + k) % NW]) return (last + k) % NW;
    end
    return -1;
  endfunction

  task automatic model_reset();
    m_st = 0; m_grp = 0; m_ngrp = 4; m_wave = 0; m_last = NW - 1; m_err = 0;
    for (int w = 0; w < NW; w++) begin
      m_mask[w] = '1; m_cnt[w] = 0; m_pc[w] = '0;
    end
  endtask

  // one clock edge of the behavioural reference, using the held inputs
  task automatic model_step();
    int p;
    logic [63:0] vm;
    if (m_st == 0) begin
      p = rr(ready_i, m_last);
      if (p >= 0) begin
        m_last = p;
        if (op_i == 2'b01) begin
          if (m_cnt[p] == DEPTH) m_err = 1;
          else begin
            m_stk[p][m_cnt[p]] = m_mask[p];
            m_cnt[p]++;
            m_mask[p] = m_mask[p] & cond_i;
          end
          m_pc[p]++;
        end else if (op_i == 2'b10) begin
          if (m_cnt[p] == 0) m_err = 1;
          else begin
            m_cnt[p]--;
            m_mask[p] = m_stk[p][m_cnt[p]];
          end
          m_pc[p]++;
        end else begin
          vm = vlen32_i ? 64'h0000_0000_FFFF_FFFF : '1;
          if ((m_mask[p] & vm) == 0) m_pc[p]++;
          else begin
            m_st = 1; m_grp = 0; m_wave = p; m_ngrp = vlen32_i ? 2 : 4;
          end
        end
      end
    end else begin
      if (m_grp == m_ngrp - 1) begin
        m_st = 0;
        m_pc[m_wave]++;
      end else begin
        m_grp++;
      end
    end
  endtask

  task automatic compare();
    int p;
    logic [15:0] exp_lane;
    p = rr(ready_i, m_last);
    exp_lane = (m_st == 1) ? m_mask[m_wave][m_grp*16 +: 16] : 16'h0;
    check(grp_valid_o == (m_st == 1), "R1/R2/R6", "grp_valid", 64'(grp_valid_o), 64'(m_st == 1));
    check(lane_en_o == exp_lane, "R3/R4/R5", "lane_en", 64'(lane_en_o), 64'(exp_lane));
    check(err_o == m_err, "R7", "err", 64'(err_o), 64'(m_err));
    check(sel_valid_o == (m_st == 0 && p >= 0), "R8", "sel_valid",
          64'(sel_valid_o), 64'(m_st == 0 && p >= 0));
    if (m_st == 0 && p >= 0)
      check(sel_wave_o == 3'(p), "R8", "sel_wave", 64'(sel_wave_o), 64'(p));
    if (m_st == 1) begin
      check(grp_idx_o == 2'(m_grp), "R1/R2", "grp_idx", 64'(grp_idx_o), 64'(m_grp));
      check(wave_id_o == 3'(m_wave), "R9", "wave_id", 64'(wave_id_o), 64'(m_wave));
      check(pc_o == m_pc[m_wave], "R10", "pc", 64'(pc_o), 64'(m_pc[m_wave]));
    end
  endtask

  task automatic cyc(input logic [NW-1:0] rdy, input logic [1:0] op,
                     input logic vl, input logic [63:0] cnd);
    @(negedge clk);
    model_step();
    ready_i = rdy; op_i = op; vlen32_i = vl; cond_i = cnd;
    #1;
    compare();
  endtask

  // one instruction followed by quiet cycles so it drains fully
  task automatic instr(input logic [NW-1:0] rdy, input logic [1:0] op,
                       input logic vl, input logic [63:0] cnd);
    cyc(rdy, op, vl, cnd);
    for (int i = 0; i < 5; i++) cyc('0, 2'b00, 1'b0, '0);
  endtask

  task automatic finish_run();
    if (!summary_done) begin
      summary_done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog R9 actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [63:0] cpat [6];
    cpat[0] = '1;
    cpat[1] = '0;
    cpat[2] = 64'hFFFF_FFFF_0000_0000;
    cpat[3] = 64'h0000_0000_FFFF_FFFF;
    cpat[4] = 64'h0F0F_00FF_F00F_A5A5;
    cpat[5] = 64'h8000_0001_0000_8001;

    rst_n = 1'b0; ready_i = '0; op_i = 2'b00; vlen32_i = 1'b0; cond_i = '0;
    model_reset();
    repeat (3) @(negedge clk);
    #1;
    compare();                                 // R11 reset state
    @(negedge clk);
    rst_n = 1'b1;

    instr(8'h81, 2'b00, 1'b0, '0);             // R11 lowest ready first, R1 four groups
    instr(8'h01, 2'b00, 1'b1, '0);             // R2 half length
    instr(8'h01, 2'b01, 1'b0, 64'h00F0_0000_FFFF_00F0); // R4 branch narrows
    instr(8'h01, 2'b00, 1'b0, '0);             // R3 lanes follow narrowed mask
    instr(8'h01, 2'b01, 1'b0, 64'hFFFF_FFFF_0000_0000); // R4 nested branch
    instr(8'h01, 2'b00, 1'b1, '0);             // R6 empty within half length: skip
    instr(8'h01, 2'b00, 1'b0, '0);             // R3 upper groups still live
    instr(8'h01, 2'b10, 1'b0, '0);             // R5 restore
    instr(8'h01, 2'b00, 1'b0, '0);
    instr(8'h01, 2'b10, 1'b0, '0);             // R5 back to all ones
    instr(8'h01, 2'b10, 1'b0, '0);             // R7 underflow
    instr(8'h01, 2'b00, 1'b0, '0);             // R7 mask unchanged
    for (int i = 0; i < 4; i++) instr(8'h04, 2'b01, 1'b0, cpat[4]); // R7 overflow
    instr(8'h04, 2'b00, 1'b0, '0);
    instr(8'h10, 2'b01, 1'b0, '0);             // R6 zero mask path
    instr(8'h10, 2'b00, 1'b0, '0);             // R6 no lane cycles
    for (int i = 0; i < 6; i++) cyc(8'hA6, 2'b00, i[0], '1); // R8 R9 round robin under load

    for (int i = 0; i < 4000; i++) begin        // mixed traffic, all requirements
      logic [NW-1:0] r;
      r = NW'($urandom) & NW'($urandom);
      cyc(r, 2'($urandom), 1'($urandom), cpat[$urandom % 6]);
    end

    for (int i = 0; i < 3; i++) cyc('0, 2'b00, 1'b0, '0);
    finish_run();
  end
endmodule